// File: doc/BRIEF.md
# MDIO Management Master

This block is a clause-22 management master for talking to Ethernet PHYs over a two-wire MDC/MDIO link. Software reaches it through a small byte-wide register bus. A 32-bit command word is spread over byte addresses 0 to 3, least significant byte at address 0. A 32-bit status word sits at byte addresses 4 to 7, in the same byte order. Command bit 31 is the go flag and bit 26 chooses the direction: 1 means write, 0 means read. Bits 25:21 hold the PHY address, bits 20:16 hold the register address, and bits 15:0 hold the data to write.

Software fills in the lower command bytes first. It then writes the top byte with bit 7 set, and that write launches a frame. The block clocks the frame out on MDC, releases MDIO for the turnaround of a read, and captures the PHY's reply. When the frame ends, hardware clears the go flag, so polling address 3 tells software the transaction is done. After a read, status bit 31 reports whether the PHY failed to pull the second turnaround bit low, and bits 15:0 hold the 16 data bits that were captured.

Top module: `mdio_master`

## Requirements
- R1: After reset, the command word and the status word read 0, `mdc` is low and `mdio_oe` is low.
- R2: A write to byte address 0, 1, 2 or 3 stores the write data in command bits 7:0, 15:8, 23:16 or 31:24 respectively. Byte addresses 4 to 7 return status bits 7:0, 15:8, 23:16 and 31:24, and reads have no side effect.
- R3: Only a write to address 3 with data bit 7 set, made while the go flag is clear, starts a frame. Any other write leaves `mdc` idle and the go flag clear.
- R4: Every frame is sent MSB first as 32 ones, then start bits 01, then opcode 10 for a read or 01 for a write, then the 5-bit PHY address, then the 5-bit register address.
- R5: A write frame continues with turnaround bits 10 and then the 16 data bits from command bits 15:0. The master drives MDIO for all 64 bits.
- R6: In a read frame, `mdio_oe` is low from bit 46 (the first turnaround bit) onward. The master samples the bit at index 47 and the 16 data bits on rising MDC edges. Status bit 31 is set when bit 47 reads 1, and status bits 15:0 take the captured data, MSB first.
- R7: MDC has a period of 2×`DIV` system clocks and a 50% duty cycle. The master changes `mdio_o` only on the system clock edge that raises MDC.
- R8: Each frame has exactly 64 rising MDC edges. The go flag clears on the falling MDC edge that follows the 64th rising edge, and MDC then stays low.
- R9: A completed write frame leaves the status word unchanged.
- R10: Command writes made while the go flag is set update the stored command bits but keep the go flag set. They neither restart nor alter the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Byte register write strobe |
| reg_addr | input | 3 | Byte register address (0-3 command, 4-7 status) |
| reg_wdata | input | 8 | Byte write data |
| reg_rdata | output | 8 | Byte read data, combinational from `reg_addr` |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data driven by the master |
| mdio_oe | output | 1 | High while the master drives MDIO |
| mdio_i | input | 1 | Serial data seen on the MDIO wire |

## Verification
A wrong bit index or a stale latched command shows up in the serial pattern captured on `mdio_o` within one MDC period of the error. A bad rising-edge count or divider count changes the measured MDC period, or moves the go-flag clear away from the 64th rising edge, which the poll of address 3 detects. A fault in the read capture path shows up in the status word as soon as the frame ends: a wrong failure flag, shifted data, or an update after a write. Writes made in the middle of a frame check that the latched frame contents stay separate from the software-visible command bytes.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       mdc,
  output logic       mdio_o,
  output logic       mdio_oe,
  input  logic       mdio_i
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int NBITS = 64;
  localparam int TA1 = 46;
  localparam int TA2 = 47;

  logic [31:0]   cmd, sts, tx;
  logic [CW-1:0] cnt;
  logic          mdc_r, wr_l;
  logic [6:0]    bidx;
  logic [16:0]   rx;

  wire go    = cmd[31];
  wire tick  = go && (cnt == CW'(DIV - 1));
  wire rise  = tick && !mdc_r;
  wire fall  = tick && mdc_r;
  wire start = reg_we && (reg_addr == 3'd3) && reg_wdata[7] && !go;
  wire [31:0] src = reg_addr[2] ? sts : cmd;

  assign reg_rdata = src[reg_addr[1:0]*8 +: 8];
  assign mdc       = mdc_r;
  assign mdio_o    = (bidx < 7'd32 || bidx >= 7'(NBITS)) ? 1'b1 : tx[~bidx[4:0]];
  assign mdio_oe   = go && (bidx < 7'(NBITS)) && (wr_l || bidx < 7'(TA1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd <= '0; sts <= '0; tx <= '0; cnt <= '0;
      mdc_r <= 1'b0; wr_l <= 1'b0; bidx <= '0; rx <= '0;
    end else begin
      if (reg_we && !reg_addr[2]) begin
        case (reg_addr[1:0])
          2'd0: cmd[7:0]   <= reg_wdata;
          2'd1: cmd[15:8]  <= reg_wdata;
          2'd2: cmd[23:16] <= reg_wdata;
          default: begin
            cmd[30:24] <= reg_wdata[6:0];
            if (!go) cmd[31] <= reg_wdata[7];
          end
        endcase
      end
      if (start) begin
        wr_l  <= reg_wdata[2];
        tx    <= {2'b01, (reg_wdata[2] ? 2'b01 : 2'b10), reg_wdata[1:0], cmd[23:21],
                  cmd[20:16], 2'b10, cmd[15:0]};
        cnt   <= '0;
        mdc_r <= 1'b0;
        bidx  <= '0;
      end else if (go) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) mdc_r <= !mdc_r;
        if (rise) begin
          if (!wr_l && bidx >= 7'(TA2)) rx <= {rx[15:0], mdio_i};
          bidx <= bidx + 1'b1;
        end
        if (fall && bidx == 7'(NBITS)) begin
          cmd[31] <= 1'b0;
          if (!wr_l) sts <= {rx[16], 15'd0, rx[15:0]};
        end
      end
    end
  end

  // R1 R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> (!mdc && !mdio_oe));

  // R7
  mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && $past(go) && !(mdc && !$past(mdc))) |-> $stable(mdio_o));

  // R7
  mdc_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(go) && (mdc != $past(mdc))) |-> ($past(cnt) == CW'(DIV - 1)));

  // R6
  ta_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !wr_l && bidx >= 7'(TA1)) |-> !mdio_oe);

  // R9
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && wr_l) |=> $stable(sts));

  // R10
  go_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !(fall && bidx == 7'(NBITS))) |=> go);
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  localparam int DIV = 4;
  logic clk = 0, rst_n = 0, reg_we = 0, mdio_i;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  int total = 0, bad = 0, rises = 0, negs = 0;
  realtime t0, t1;
  logic [63:0] cap;
  logic oe_ta, phy_on, phy_ta2, phy_drv = 1;
  logic [15:0] phy_data;

  always #4 clk = ~clk;
  assign mdio_i = phy_drv;

  mdio_master #(.DIV(DIV)) u_dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always @(posedge mdc) begin
    if (rises == 0) t0 = $realtime;
    if (rises == 1) t1 = $realtime;
    rises++;
  end

  always @(negedge mdc) begin
    automatic int b = negs + 1;
    negs++;
    if (b <= 63) cap[63-b] = mdio_o;
    if (b == 46) oe_ta = mdio_oe;
    if (!phy_on || b == 46 || b > 63) phy_drv = 1'b1;
    else if (b == 47) phy_drv = phy_ta2;
    else if (b >= 48) phy_drv = phy_data[63-b];
    else phy_drv = 1'b1;
  end

  function automatic logic [63:0] exp_frame(bit wr, logic [4:0] pa, logic [4:0] ra, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), pa, ra, 2'b10, d};
  endfunction

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wbyte(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rword(bit hi, output logic [31:0] v);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      reg_addr = {hi, 2'(i)}; #0.1; v[i*8 +: 8] = reg_rdata;
    end
  endtask

  task automatic launch(bit wr, logic [4:0] pa, logic [4:0] ra, logic [15:0] d);
    wbyte(3'd0, d[7:0]); wbyte(3'd1, d[15:8]); wbyte(3'd2, {pa[2:0], ra});
    rises = 0; negs = 0; cap = '1;
    wbyte(3'd3, {1'b1, 4'd0, wr, pa[4:3]});
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rword(1'b0, v);
      if (!v[31]) break;
    end
  endtask

  task automatic txn(bit wr, logic [4:0] pa, logic [4:0] ra, logic [15:0] d,
                     bit on, bit ta2, logic [15:0] pd, logic [31:0] sts_prev);
    logic [31:0] s;
    phy_on = on; phy_ta2 = ta2; phy_data = pd;
    launch(wr, pa, ra, d);
    wait_done();
    chk("R8 rise count", 64'(rises), 64'd64);
    chk("R7 mdc period", 64'(int'(t1 - t0)), 64'(2*DIV*8));
    if (wr) chk("R5 write frame", cap, exp_frame(1, pa, ra, d));
    else begin
      chk("R4 read header", {cap[63:18], 18'd0}, {exp_frame(0, pa, ra, 0) & ~64'h3FFFF});
      chk("R6 oe released", 64'(oe_ta), 64'd0);
    end
    rword(1'b1, s);
    if (wr) chk("R9 status kept", 64'(s), 64'(sts_prev));
    else if (!on) chk("R6 absent phy", 64'(s), 64'h8000FFFF);
    else chk("R6 read status", 64'(s), 64'({ta2, 15'd0, pd}));
  endtask

  initial begin
    #(8*150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, sv;
    void'($urandom(32'd11));
    phy_on = 1; phy_ta2 = 0; phy_data = 0; oe_ta = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    rword(1'b0, v); chk("R1 cmd reset", 64'(v), 0);
    rword(1'b1, v); chk("R1 sts reset", 64'(v), 0);
    chk("R1 idle pins", {62'd0, mdc, mdio_oe}, 0);

    rises = 0;
    wbyte(3'd0, 8'hAA); wbyte(3'd1, 8'hBB); wbyte(3'd2, 8'hCC); wbyte(3'd3, 8'h45);
    rword(1'b0, v); chk("R2 byte map", 64'(v), 64'h45CCBBAA);
    repeat (4*DIV) @(negedge clk);
    chk("R3 no start", 64'(rises), 0);

    txn(1, 5'h1F, 5'h00, 16'hA55A, 1, 0, 16'h0, 32'h0);
    txn(0, 5'h01, 5'h1E, 16'h0, 1, 0, 16'h8001, 32'h0);
    txn(0, 5'h15, 5'h02, 16'h0, 0, 1, 16'h0, 32'h0);
    txn(1, 5'h00, 5'h1F, 16'hFFFF, 1, 0, 16'h0, 32'h8000FFFF);

    phy_on = 1; phy_ta2 = 0; phy_data = 16'h1234;
    launch(0, 5'h0A, 5'h05, 16'h0);
    repeat (20*DIV) @(negedge clk);
    wbyte(3'd0, 8'h33); wbyte(3'd3, 8'hFF); wbyte(3'd2, 8'h00);
    wait_done();
    chk("R10 no restart", 64'(rises), 64'd64);
    chk("R10 frame intact", {cap[63:18], 18'd0}, {exp_frame(0, 5'h0A, 5'h05, 0) & ~64'h3FFFF});
    rword(1'b0, v); chk("R10 fields updated", 64'(v), 64'h7F000033);
    rword(1'b1, v); chk("R6 read after edits", 64'(v), 64'h00001234);
    sv = v;

    for (int k = 0; k < 8; k++) begin
      automatic bit wr = $urandom % 2;
      automatic bit ta2 = ($urandom % 4) == 0;
      automatic logic [4:0] pa = 5'($urandom);
      automatic logic [4:0] ra = 5'($urandom);
      automatic logic [15:0] d = 16'($urandom);
      automatic logic [15:0] pd = 16'($urandom);
      txn(wr, pa, ra, d, 1, ta2, pd, sv);
      if (!wr) sv = {ta2, 15'd0, pd};
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule